// File: doc/BRIEF.md
# I2C Command Sequencer

This block is the programmable control core of an I2C host. Software fills up to 32 command slots with 5-bit opcodes, sets the target address, the loop count and the loop destination, preloads transmit bytes, and then launches the program. The sequencer walks the slots from slot 0. For each bus opcode it hands one primitive (start, repeated start, stop, write byte, read byte, read ACK bit, write ACK bit) to an external bit-timing engine and waits for that engine's done pulse. A counted jump repeats a transfer body, so an N-byte transfer needs only a handful of slots.

Two 64-entry byte FIFOs connect the program to software. One supplies outgoing data and the other collects received bytes. Each FIFO has a watermark. A sticky raw interrupt register records completion, NACK aborts and FIFO thresholds. An enable register masks it, and the single `irq` output is the OR of the masked bits.

The controller has three states. `S_IDLE` moves to `S_DECODE` on launch. `S_DECODE` executes a jump or a FIFO load in place and stays in `S_DECODE`. For a bus opcode it moves to `S_BUS`. On exit, on an undefined opcode, or after the last slot it returns to `S_IDLE`. `S_BUS` holds the primitive request until done arrives. It then goes back to `S_DECODE`, or to `S_IDLE` when a checked ACK bit is a NACK.

Top module: `cmdseq_top`

## Requirements
- R1: After reset the status word (word 8) reads 0x0008_0000 (bit 19 TX FIFO not full, bit 16 RX FIFO not empty, bit 0 busy), the raw interrupt word (word 9) reads 0 and `irq` is low.
- R2: Writing 1 to bit 0 of word 0 while idle starts execution at slot 0 (slot n is word 32+n). Slots then run in order. Opcode 0x00 ends the program, sets raw bit 12 and clears busy.
- R3: Opcodes 0x01, 0x1E and 0x1F issue primitives 0 (start), 1 (repeated start) and 2 (stop). Opcodes 0x16 and 0x17 issue primitive 6 (write ACK bit) with `prim_byte[0]` set to 0 and 1 respectively. While `prim_req` is high and `prim_done` is low, the primitive code and byte stay stable.
- R4: Opcode 0x04 writes (primitive 3) bits 15:8 of the address register (word 1). Opcode 0x05 writes bits 7:0 of that register.
- R5: Opcode 0x1D moves the head of the TX FIFO (filled through word 6) into a holding byte. Opcode 0x09 writes that holding byte on the bus.
- R6: Opcode 0x18 jumps to the slot held in word 3 and decrements the loop count (word 2) while the count is nonzero. Otherwise it falls through. A count of L runs the body L+1 times and leaves the count at 0.
- R7: Opcode 0x13 issues primitive 5. If the returned bit is 1 (NACK), the program stops with no further primitive and raw bits 0 and 11 are set, with bit 12 left clear. Opcode 0x15 issues the same primitive and continues whatever bit returns.
- R8: Opcode 0x12 issues primitive 4 and pushes the returned byte into the RX FIFO. A read of word 7 pops that FIFO in arrival order, and status bit 16 reports it non-empty.
- R9: Opcode 0x1D with an empty TX FIFO, or 0x12 with a full RX FIFO (64 bytes), waits with no bus activity. The program resumes once software pushes or pops.
- R10: While busy, raw bit 2 sets when the RX count is at least the RX watermark (word 5) and raw bit 4 sets when the TX count is below the TX watermark (word 4). Both watermarks reset to 32.
- R11: Word 11 reads raw AND enable (word 10), and `irq` is its OR. Writing ones to word 9 clears those raw bits.
- R12: Any undefined opcode behaves as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX FIFO at word 7) |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| prim_req | output | 1 | Primitive request to bit-timing engine |
| prim_op | output | 3 | Primitive code 0..6 |
| prim_byte | output | 8 | Byte to write, or ACK bit in bit 0 |
| prim_done | input | 1 | One-cycle completion pulse from the engine |
| prim_rx_byte | input | 8 | Byte received by a read primitive |
| prim_rx_bit | input | 1 | ACK bit received (1 = NACK) |
| irq | output | 1 | OR of masked interrupt bits |

## Verification
A wrong program counter or loop count shows at the ports as a wrong, missing or extra entry in the byte stream the bench target model records. A wrong jump decision does the same. The fault appears at the first primitive after the faulty step, within a few cycles. A corrupted FIFO pointer shows up as a wrong byte order on the bus or at the RX data word. Sequencer state that fails to return to idle, or that skips the abort path, shows within a cycle of the exit or NACK. It appears in the busy status bit and in raw interrupt bits 0, 11 and 12.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
    typedef enum logic [4:0] {
        OP_EXIT    = 5'h00,
        OP_START   = 5'h01,
        OP_ADDR_HI = 5'h04,
        OP_ADDR_LO = 5'h05,
        OP_TXB     = 5'h09,
        OP_RXB     = 5'h12,
        OP_ACKCHK  = 5'h13,
        OP_ACKIGN  = 5'h15,
        OP_SACK    = 5'h16,
        OP_SNACK   = 5'h17,
        OP_JMP     = 5'h18,
        OP_UPTX    = 5'h1D,
        OP_RSTART  = 5'h1E,
        OP_STOP    = 5'h1F
    } opcode_e;

    typedef enum logic [2:0] {
        PR_START, PR_RSTART, PR_STOP, PR_WRBYTE, PR_RDBYTE, PR_RDACK, PR_WRACK
    } prim_e;

    typedef enum logic [1:0] {S_IDLE, S_DECODE, S_BUS} seq_state_e;

    typedef enum logic [3:0] {
        RG_CTRL, RG_ADDR, RG_LOOP, RG_DEST, RG_TXWM, RG_RXWM, RG_TXDATA,
        RG_RXDATA, RG_STATUS, RG_RAW, RG_IEN, RG_MASKED
    } reg_e;

    localparam int IRQ_ABORT_A = 0;
    localparam int IRQ_RXTH    = 2;
    localparam int IRQ_TXTH    = 4;
    localparam int IRQ_ABORT_B = 11;
    localparam int IRQ_DONE    = 12;
    localparam int ST_RXNE     = 16;
    localparam int ST_TXNF     = 19;
endpackage

// File: rtl/cmdseq_fifo.sv
module cmdseq_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= wp + 1'b1;
            end
            if (do_pop) rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/cmdseq_engine.sv
module cmdseq_engine
    import cmdseq_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int LOOP_W = 16,
    localparam int PCW   = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [4:0]        op,
    output logic [PCW-1:0]    pc,
    input  logic [15:0]       tgt_addr,
    input  logic              tx_empty,
    input  logic [7:0]        tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic              prim_req,
    output logic [2:0]        prim_op,
    output logic [7:0]        prim_byte,
    input  logic              prim_done,
    input  logic              prim_rx_bit,
    input  logic              loop_wr,
    input  logic [LOOP_W-1:0] loop_din,
    input  logic              dest_wr,
    input  logic [PCW-1:0]    dest_din,
    output logic [LOOP_W-1:0] loop_q,
    output logic [PCW-1:0]    dest_q,
    output logic              busy,
    output logic              done_pulse,
    output logic              abort_pulse
);
    seq_state_e st, nxt;
    logic [4:0] cur_op;
    logic [7:0] tx_hold, p_byte;
    prim_e      p_op;
    logic       issue, adv, jump, fin, abrt;

    // next state and step decisions
    always_comb begin
        nxt = st; issue = 1'b0; adv = 1'b0; jump = 1'b0; fin = 1'b0; abrt = 1'b0;
        tx_pop = 1'b0; rx_push = 1'b0; p_op = PR_START; p_byte = 8'h00;
        unique case (st)
            S_IDLE: if (launch) nxt = S_DECODE;
            S_DECODE: begin
                unique case (op)
                    OP_START:   issue = 1'b1;
                    OP_RSTART:  begin issue = 1'b1; p_op = PR_RSTART; end
                    OP_STOP:    begin issue = 1'b1; p_op = PR_STOP; end
                    OP_ADDR_HI: begin issue = 1'b1; p_op = PR_WRBYTE; p_byte = tgt_addr[15:8]; end
                    OP_ADDR_LO: begin issue = 1'b1; p_op = PR_WRBYTE; p_byte = tgt_addr[7:0]; end
                    OP_TXB:     begin issue = 1'b1; p_op = PR_WRBYTE; p_byte = tx_hold; end
                    OP_RXB:     begin issue = !rx_full; p_op = PR_RDBYTE; end
                    OP_ACKCHK,
                    OP_ACKIGN:  begin issue = 1'b1; p_op = PR_RDACK; end
                    OP_SACK:    begin issue = 1'b1; p_op = PR_WRACK; end
                    OP_SNACK:   begin issue = 1'b1; p_op = PR_WRACK; p_byte = 8'h01; end
                    OP_JMP:     begin jump = (loop_q != '0); adv = (loop_q == '0); end
                    OP_UPTX:    begin tx_pop = !tx_empty; adv = !tx_empty; end
                    default:    begin fin = 1'b1; nxt = S_IDLE; end
                endcase
                if (issue) nxt = S_BUS;
            end
            S_BUS: begin
                if (prim_done) begin
                    rx_push = (cur_op == OP_RXB);
                    if (cur_op == OP_ACKCHK && prim_rx_bit) begin
                        abrt = 1'b1;
                        nxt  = S_IDLE;
                    end else begin
                        adv = 1'b1;
                        nxt = S_DECODE;
                    end
                end
            end
            default: nxt = S_IDLE;
        endcase
        if (adv && pc == PCW'(SLOTS - 1)) begin
            fin = 1'b1;
            nxt = S_IDLE;
        end
    end

    // state register and program datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; pc <= '0; loop_q <= '0; dest_q <= '0;
            tx_hold <= '0; cur_op <= '0; prim_op <= '0; prim_byte <= '0;
        end else begin
            st <= nxt;
            if (st == S_IDLE && launch) pc <= '0;
            else if (jump)              pc <= dest_q;
            else if (adv)               pc <= pc + 1'b1;
            if (st == S_IDLE && loop_wr) loop_q <= loop_din;
            else if (jump)               loop_q <= loop_q - 1'b1;
            if (st == S_IDLE && dest_wr) dest_q <= dest_din;
            if (tx_pop) tx_hold <= tx_data;
            if (issue) begin
                cur_op    <= op;
                prim_op   <= p_op;
                prim_byte <= p_byte;
            end
        end
    end

    // outputs
    always_comb begin
        prim_req    = (st == S_BUS);
        busy        = (st != S_IDLE);
        done_pulse  = fin;
        abort_pulse = abrt;
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_req && !prim_done) |=> (prim_req && $stable(prim_op) && $stable(prim_byte)));
endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
    import cmdseq_pkg::*;
#(
    parameter int SLOTS    = 32,
    parameter int FDEPTH   = 64,
    parameter int LOOP_W   = 16,
    localparam int PCW     = $clog2(SLOTS),
    localparam int ADDR_W  = PCW + 1,
    localparam int CW      = $clog2(FDEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              prim_req,
    output logic [2:0]        prim_op,
    output logic [7:0]        prim_byte,
    input  logic              prim_done,
    input  logic [7:0]        prim_rx_byte,
    input  logic              prim_rx_bit,
    output logic              irq
);
    logic [4:0]        slots [SLOTS];
    logic [15:0]       tgt_addr;
    logic [CW-1:0]     tx_wm, rx_wm, tx_cnt, rx_cnt;
    logic [31:0]       raw, ien, raw_set, masked;
    logic              lo_sel, slot_sel;
    logic [3:0]        ridx;
    logic [PCW-1:0]    pc, dest_q;
    logic [LOOP_W-1:0] loop_q;
    logic [7:0]        tx_dout, rx_dout;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              seq_tx_pop, seq_rx_push, busy, done_p, abort_p;

    assign slot_sel = reg_addr[ADDR_W-1];
    assign lo_sel   = (reg_addr[ADDR_W-1:4] == '0);
    assign ridx     = reg_addr[3:0];

    function automatic logic wr_hit(input logic [3:0] r);
        return reg_wr && lo_sel && (ridx == r);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
            tgt_addr <= '0;
            tx_wm    <= CW'(FDEPTH / 2);
            rx_wm    <= CW'(FDEPTH / 2);
            raw      <= '0;
            ien      <= '0;
        end else begin
            if (reg_wr && slot_sel) slots[reg_addr[PCW-1:0]] <= reg_wdata[4:0];
            if (wr_hit(RG_ADDR)) tgt_addr <= reg_wdata[15:0];
            if (wr_hit(RG_TXWM)) tx_wm    <= reg_wdata[CW-1:0];
            if (wr_hit(RG_RXWM)) rx_wm    <= reg_wdata[CW-1:0];
            if (wr_hit(RG_IEN))  ien      <= reg_wdata;
            raw <= (raw & ~(wr_hit(RG_RAW) ? reg_wdata : 32'h0)) | raw_set;
        end
    end

    always_comb begin
        raw_set              = '0;
        raw_set[IRQ_ABORT_A] = abort_p;
        raw_set[IRQ_ABORT_B] = abort_p;
        raw_set[IRQ_DONE]    = done_p;
        raw_set[IRQ_RXTH]    = busy && (rx_cnt >= rx_wm);
        raw_set[IRQ_TXTH]    = busy && (tx_cnt < tx_wm);
        masked               = raw & ien;
        irq                  = |masked;
    end

    always_comb begin
        reg_rdata = '0;
        if (slot_sel) reg_rdata[4:0] = slots[reg_addr[PCW-1:0]];
        else if (lo_sel) begin
            unique case (ridx)
                RG_ADDR:   reg_rdata[15:0]     = tgt_addr;
                RG_LOOP:   reg_rdata[LOOP_W-1:0] = loop_q;
                RG_DEST:   reg_rdata[PCW-1:0]  = dest_q;
                RG_TXWM:   reg_rdata[CW-1:0]   = tx_wm;
                RG_RXWM:   reg_rdata[CW-1:0]   = rx_wm;
                RG_RXDATA: reg_rdata[7:0]      = rx_dout;
                RG_STATUS: begin
                    reg_rdata[0]        = busy;
                    reg_rdata[ST_RXNE]  = !rx_empty;
                    reg_rdata[ST_TXNF]  = !tx_full;
                end
                RG_RAW:    reg_rdata = raw;
                RG_IEN:    reg_rdata = ien;
                RG_MASKED: reg_rdata = masked;
                default:   reg_rdata = '0;
            endcase
        end
    end

    cmdseq_fifo #(.DEPTH(FDEPTH), .W(8)) u_txf (
        .clk(clk), .rst_n(rst_n), .push(wr_hit(RG_TXDATA)), .din(reg_wdata[7:0]),
        .pop(seq_tx_pop), .dout(tx_dout), .count(tx_cnt), .empty(tx_empty), .full(tx_full));

    cmdseq_fifo #(.DEPTH(FDEPTH), .W(8)) u_rxf (
        .clk(clk), .rst_n(rst_n), .push(seq_rx_push), .din(prim_rx_byte),
        .pop(reg_rd && lo_sel && ridx == RG_RXDATA), .dout(rx_dout), .count(rx_cnt),
        .empty(rx_empty), .full(rx_full));

    cmdseq_engine #(.SLOTS(SLOTS), .LOOP_W(LOOP_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .launch(wr_hit(RG_CTRL) && reg_wdata[0]),
        .op(slots[pc]), .pc(pc), .tgt_addr(tgt_addr),
        .tx_empty(tx_empty), .tx_data(tx_dout), .tx_pop(seq_tx_pop),
        .rx_full(rx_full), .rx_push(seq_rx_push),
        .prim_req(prim_req), .prim_op(prim_op), .prim_byte(prim_byte),
        .prim_done(prim_done), .prim_rx_bit(prim_rx_bit),
        .loop_wr(wr_hit(RG_LOOP)), .loop_din(reg_wdata[LOOP_W-1:0]),
        .dest_wr(wr_hit(RG_DEST)), .dest_din(reg_wdata[PCW-1:0]),
        .loop_q(loop_q), .dest_q(dest_q), .busy(busy),
        .done_pulse(done_p), .abort_pulse(abort_p));

    assert_rx_push_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_rx_push |-> !rx_full);
    assert_tx_pop_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_tx_pop |-> !tx_empty);
    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[IRQ_DONE]) |-> !busy);
    assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[IRQ_ABORT_B]) |-> (!busy && !prim_req));
endmodule

// File: tb/cmdseq_top_tb.sv
`timescale 1ns/1ps
module cmdseq_top_tb;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        prim_req, irq;
    logic [2:0]  prim_op;
    logic [7:0]  prim_byte;
    logic        prim_done = 1'b0, prim_rx_bit = 1'b0;
    logic [7:0]  prim_rx_byte = '0;

    always #2 clk = ~clk;

    cmdseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prim_req(prim_req), .prim_op(prim_op),
        .prim_byte(prim_byte), .prim_done(prim_done), .prim_rx_byte(prim_rx_byte),
        .prim_rx_bit(prim_rx_bit), .irq(irq));

    int checks = 0, errors = 0;
    bit finished = 0;

    // target model: tag byte 1 S,2 Sr,3 P,4 written byte,5 read byte,6 ACK sent,7 ACK received
    int          dly = 0, rd_idx = 0, got_n = 0, exp_n = 0;
    logic        nack_mode = 1'b0;
    logic [7:0]  rd_base = 8'h00;
    logic [15:0] got [0:255];
    logic [15:0] expl [0:127];
    logic [15:0] ent;

    always @(negedge clk) begin
        if (prim_done) prim_done = 1'b0;
        else if (prim_req) begin
            if (dly < 2) dly++;
            else begin
                dly = 0;
                case (prim_op)
                    3'd0: ent = 16'h0100;
                    3'd1: ent = 16'h0200;
                    3'd2: ent = 16'h0300;
                    3'd3: ent = {8'h04, prim_byte};
                    3'd4: begin
                        prim_rx_byte = rd_base + 8'(rd_idx);
                        rd_idx++;
                        ent = {8'h05, prim_rx_byte};
                    end
                    3'd5: begin prim_rx_bit = nack_mode; ent = {8'h07, 7'b0, nack_mode}; end
                    3'd6: ent = {8'h06, 7'b0, prim_byte[0]};
                    default: ent = 16'hFFFF;
                endcase
                if (got_n < 256) got[got_n] = ent;
                got_n++;
                prim_done = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic pop(output logic [31:0] d);
        @(negedge clk); reg_addr = 6'd7; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic cmd(input int slot, input logic [4:0] op);
        wr(6'(32 + slot), {27'b0, op});
    endtask

    task automatic run_and_wait();
        logic [31:0] s;
        got_n = 0; rd_idx = 0;
        wr(6'd9, 32'hFFFF_FFFF);
        wr(6'd0, 32'h1);
        for (int i = 0; i < 20000; i++) begin
            rd(6'd8, s);
            if (!s[0]) break;
        end
    endtask

    task automatic exp(input logic [15:0] e);
        expl[exp_n] = e; exp_n++;
    endtask

    task automatic check_log(input string req);
        int bad = -1;
        for (int i = 0; i < exp_n && i < got_n; i++) if (got[i] !== expl[i] && bad < 0) bad = i;
        if (got_n != exp_n) check(0, req, "bus entry count", got_n, exp_n);
        else if (bad >= 0) check(0, req, "bus entry", {16'(bad), got[bad]}, {16'(bad), expl[bad]});
        else check(1, req, "bus log", 0, 0);
        exp_n = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(6'd8, d); check(d == 32'h0008_0000, "R1", "status", d, 32'h0008_0000);
        rd(6'd9, d); check(d == 0, "R1", "raw", d, 0);
        check(irq == 1'b0, "R1", "irq", irq, 0);
    endtask

    task automatic t_write();
        logic [31:0] d;
        wr(6'd1, 32'h00A0);
        wr(6'd6, 32'h11); wr(6'd6, 32'h22); wr(6'd6, 32'h33);
        cmd(0, 5'h01); cmd(1, 5'h05); cmd(2, 5'h13); cmd(3, 5'h1D); cmd(4, 5'h09);
        cmd(5, 5'h13); cmd(6, 5'h18); cmd(7, 5'h1F); cmd(8, 5'h00);
        wr(6'd2, 32'd2); wr(6'd3, 32'd3);
        run_and_wait();
        exp(16'h0100); exp(16'h04A0); exp(16'h0700);
        exp(16'h0411); exp(16'h0700); exp(16'h0422); exp(16'h0700);
        exp(16'h0433); exp(16'h0700); exp(16'h0300);
        check_log("R2 R4 R5 R6 write loop");
        rd(6'd9, d); check(d == 32'h0000_1010, "R2", "raw after write", d, 32'h1010);
        rd(6'd2, d); check(d == 0, "R6", "loop count end", d, 0);
        rd(6'd8, d); check(d == 32'h0008_0000, "R2", "status idle", d, 32'h0008_0000);
    endtask

    task automatic load_read_prog();
        cmd(0, 5'h01); cmd(1, 5'h04); cmd(2, 5'h05); cmd(3, 5'h13); cmd(4, 5'h1E);
        cmd(5, 5'h04); cmd(6, 5'h13); cmd(7, 5'h12); cmd(8, 5'h16); cmd(9, 5'h18);
        cmd(10, 5'h12); cmd(11, 5'h17); cmd(12, 5'h1F); cmd(13, 5'h00);
        wr(6'd3, 32'd7);
    endtask

    task automatic t_read();
        logic [31:0] d;
        wr(6'd1, 32'hF5A5); rd_base = 8'hC1;
        load_read_prog(); wr(6'd2, 32'd2);
        run_and_wait();
        exp(16'h0100); exp(16'h04F5); exp(16'h04A5); exp(16'h0700); exp(16'h0200);
        exp(16'h04F5); exp(16'h0700);
        exp(16'h05C1); exp(16'h0600); exp(16'h05C2); exp(16'h0600);
        exp(16'h05C3); exp(16'h0600); exp(16'h05C4); exp(16'h0601); exp(16'h0300);
        check_log("R3 R4 R6 read loop");
        rd(6'd9, d); check(d == 32'h0000_1010, "R10", "raw below rx wm", d, 32'h1010);
        rd(6'd8, d); check(d == 32'h0009_0000, "R8", "rx not empty", d, 32'h0009_0000);
        for (int i = 0; i < 4; i++) begin
            pop(d); check(d[7:0] == 8'hC1 + 8'(i), "R8", "rx order", d, 8'hC1 + 8'(i));
        end
        rd(6'd8, d); check(d == 32'h0008_0000, "R8", "rx drained", d, 32'h0008_0000);
    endtask

    task automatic t_threshold();
        logic [31:0] d;
        wr(6'd5, 32'd2); wr(6'd4, 32'd0); wr(6'd2, 32'd2);
        run_and_wait();
        rd(6'd9, d); check(d == 32'h0000_1004, "R10", "rx wm hit, tx wm 0", d, 32'h1004);
        for (int i = 0; i < 4; i++) pop(d);
        wr(6'd5, 32'd32); wr(6'd4, 32'd32);
        exp_n = 0;
    endtask

    task automatic t_abort();
        logic [31:0] d;
        wr(6'd1, 32'h00A0); nack_mode = 1'b1;
        cmd(0, 5'h01); cmd(1, 5'h05); cmd(2, 5'h13); cmd(3, 5'h1F); cmd(4, 5'h00);
        run_and_wait();
        exp(16'h0100); exp(16'h04A0); exp(16'h0701);
        check_log("R7 abort stops");
        rd(6'd9, d); check(d == 32'h0000_0811, "R7", "abort raw bits", d, 32'h0811);
        cmd(2, 5'h15);
        run_and_wait();
        exp(16'h0100); exp(16'h04A0); exp(16'h0701); exp(16'h0300);
        check_log("R7 ignored NACK");
        rd(6'd9, d); check(d == 32'h0000_1010, "R7", "ignore raw", d, 32'h1010);
        nack_mode = 1'b0;
    endtask

    task automatic t_undef_irq();
        logic [31:0] d;
        cmd(0, 5'h01); cmd(1, 5'h07);
        wr(6'd10, 32'h1000);
        run_and_wait();
        exp(16'h0100); check_log("R12 undefined opcode");
        rd(6'd9, d);  check(d == 32'h1010, "R12", "done on undefined", d, 32'h1010);
        rd(6'd11, d); check(d == 32'h1000, "R11", "masked", d, 32'h1000);
        check(irq == 1'b1, "R11", "irq set", irq, 1);
        wr(6'd9, 32'h1000);
        rd(6'd9, d);  check(d == 32'h0010, "R11", "w1c done", d, 32'h0010);
        check(irq == 1'b0, "R11", "irq clear", irq, 0);
        wr(6'd10, 32'h0010);
        rd(6'd11, d); check(d == 32'h0010 && irq, "R11", "tx mask", d, 32'h0010);
        wr(6'd9, 32'hFFFF_FFFF); wr(6'd10, 32'h0);
        rd(6'd9, d);  check(d == 0 && !irq, "R11", "clear all", d, 0);
    endtask

    task automatic t_ctrl_prims();
        cmd(0, 5'h01); cmd(1, 5'h1E); cmd(2, 5'h16); cmd(3, 5'h17); cmd(4, 5'h1F); cmd(5, 5'h00);
        run_and_wait();
        exp(16'h0100); exp(16'h0200); exp(16'h0600); exp(16'h0601); exp(16'h0300);
        check_log("R3 control primitives");
    endtask

    task automatic t_rx_stall();
        logic [31:0] d;
        int n1;
        wr(6'd1, 32'hF5A5); rd_base = 8'h10;
        load_read_prog(); wr(6'd2, 32'd64);
        got_n = 0; rd_idx = 0;
        wr(6'd9, 32'hFFFF_FFFF); wr(6'd0, 32'h1);
        repeat (2000) @(posedge clk);
        n1 = got_n;
        repeat (100) @(posedge clk);
        rd(6'd8, d);
        check(d[0] && got_n == n1 && rd_idx == 64, "R9", "rx full stall", {d[0], 7'(rd_idx)}, {1'b1, 7'd64});
        pop(d); check(d[7:0] == 8'h10, "R9", "first byte", d, 8'h10);
        for (int i = 0; i < 2000; i++) begin
            rd(6'd8, d);
            if (!d[0]) break;
        end
        check(rd_idx == 65, "R9", "resumed all bytes", rd_idx, 65);
        for (int i = 1; i < 65; i++) begin
            pop(d);
            if (i == 64) check(d[7:0] == 8'h50, "R9", "last byte", d, 8'h50);
        end
        exp_n = 0;
    endtask

    task automatic t_tx_stall();
        logic [31:0] d;
        wr(6'd1, 32'h00A0); wr(6'd6, 32'h77);
        cmd(0, 5'h01); cmd(1, 5'h05); cmd(2, 5'h13); cmd(3, 5'h1D); cmd(4, 5'h09);
        cmd(5, 5'h13); cmd(6, 5'h18); cmd(7, 5'h1F); cmd(8, 5'h00);
        wr(6'd2, 32'd1); wr(6'd3, 32'd3);
        got_n = 0;
        wr(6'd9, 32'hFFFF_FFFF); wr(6'd0, 32'h1);
        repeat (300) @(posedge clk);
        rd(6'd8, d);
        check(d[0] && got_n == 5, "R9", "tx empty stall", {d[0], 7'(got_n)}, {1'b1, 7'd5});
        wr(6'd6, 32'h88);
        for (int i = 0; i < 2000; i++) begin
            rd(6'd8, d);
            if (!d[0]) break;
        end
        exp(16'h0100); exp(16'h04A0); exp(16'h0700); exp(16'h0477); exp(16'h0700);
        exp(16'h0488); exp(16'h0700); exp(16'h0300);
        check_log("R5 R9 resumed write");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_threshold();
        t_abort();
        t_ctrl_prims();
        t_undef_irq();
        t_tx_stall();
        t_rx_stall();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog run did not complete actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule